// File: doc/BRIEF.md
# I2C Master Serial-Clock Waveform Generator

This block produces the serial clock of an I2C bus master from a prescaled clock-enable strobe. The low and the high part of each serial-clock period are set independently by two 16-bit divisors. Each phase lasts its divisor plus a fixed offset `D_OFF`, counted in strobe periods. Software reaches the two divisors through a small register port. The port ignores writes unless the controller is held in its reset state by the run control input.

The waveform runs only while the controller is out of reset and the master-enable input is set. At any other time the clock line is released high and the phase counter is cleared. After activation, the first phase is always a low phase, and it begins on the first strobe. A one-cycle pulse marks every rising and every falling edge of the generated clock, for the data-shifting logic nearby.

Top module: `scl_waveform_gen`

## Requirements
- R1: With the waveform running, each low phase of `scl` lasts (low divisor + `D_OFF`) periods of `tick`. Default `D_OFF` is 5.
- R2: With the waveform running, each high phase of `scl` lasts (high divisor + `D_OFF`) periods of `tick`.
- R3: Register address 0 selects the low divisor and address 1 selects the high divisor. Each divisor sits in bits 15:0 of `reg_rdata` for the address on `reg_addr`. Both divisors are 0 after `rst_n` is low at a clock edge.
- R4: Bits 31:16 of `reg_rdata` always read 0. The values written to `reg_wdata[31:16]` have no effect on any divisor.
- R5: A write (`reg_wr`=1) is accepted only while `run_en`=0. A write made while `run_en`=1 leaves both divisors and the running waveform unchanged.
- R6: While `run_en`=0 or `master_en`=0, `scl` is 1 and `scl_rise` and `scl_fall` are 0. Clearing either input stops the waveform: from the next clock, `scl` is 1.
- R7: A divisor of 0 gives a phase of exactly `D_OFF` tick periods. A divisor of 0xFFFF gives 65540 tick periods, with no counter wrap.
- R8: When the waveform is activated, the first phase is low. `scl` falls on the clock edge of the first `tick` seen while active.
- R9: `scl_fall` is 1 for exactly the first clock cycle in which `scl` is low, and `scl_rise` is 1 for exactly the first clock cycle in which `scl` is high. The pulses occur at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Prescaled clock-enable strobe, one cycle wide |
| run_en | input | 1 | Controller run control; 0 holds the controller in reset and unlocks the divisors |
| master_en | input | 1 | 1 when the module is bus master |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 low divisor, 1 high divisor |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the register at `reg_addr` |
| scl | output | 1 | Generated serial clock, idle high |
| scl_rise | output | 1 | One-cycle pulse at each rising edge of `scl` |
| scl_fall | output | 1 | One-cycle pulse at each falling edge of `scl` |

## Verification
The phase lengths are measured with the strobe present on every clock and again with the strobe on every third clock. The second case shows whether the counter advances on the strobe or on the raw clock. Three kinds of divisor are used: unequal values, where a swapped pair of divisors shows up; both divisors zero, where an off-by-one in the offset shows up; and a low divisor of 0xFFFF, where a narrow counter would wrap. Writes are made with ones in the upper data bits and also while running, and the bench reads each divisor back and measures the waveform again after each such write. The master-enable and run inputs are dropped both during idle and in mid-phase, which tells an immediate release apart from one that waits for the end of the phase.

// File: rtl/scl_gen_pkg.sv
// Shared definitions for the serial-clock waveform generator.
package scl_gen_pkg;
    // Phase of the generated serial clock
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

    // Register addresses; software decodes these
    localparam logic ADDR_LOW  = 1'b0;
    localparam logic ADDR_HIGH = 1'b1;
endpackage

// File: rtl/scl_div_regs.sv
// Divisor register pair.
// What it does: holds the low-time and high-time divisors and returns the
// addressed one zero-extended to the register width.
// Assumes: lock is high whenever the controller runs, and writes are ignored
// while it is high.
module scl_div_regs #(
    parameter int DIV_W = 16,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock,
    input  logic             wr_en,
    input  logic             sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic [DIV_W-1:0] low_div,
    output logic [DIV_W-1:0] high_div
);
    import scl_gen_pkg::*;

    localparam int REG_N = 2;
    localparam int PAD_W = REG_W - DIV_W;

    logic [DIV_W-1:0] div_q [REG_N];
    logic             unused_upper;

    assign unused_upper = ^wr_data[REG_W-1:DIV_W];

    genvar gi;
    generate
        for (gi = 0; gi < REG_N; gi++) begin : g_div
            // Load one divisor from the low data bits while unlocked
            always_ff @(posedge clk) begin
                if (!rst_n)
                    div_q[gi] <= '0;
                else if (wr_en && !lock && (int'(sel) == gi))
                    div_q[gi] <= wr_data[DIV_W-1:0];
            end
        end
    endgenerate

    assign low_div  = div_q[int'(ADDR_LOW)];
    assign high_div = div_q[int'(ADDR_HIGH)];
    assign rd_data  = {{PAD_W{1'b0}}, div_q[sel]};

    // R5: divisors hold while locked
    a_r5_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(low_div) && $stable(high_div)));

    // R4: upper write bits never reach the stored divisor
    a_r4_upper_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !lock && !sel) |=> (low_div == $past(wr_data[DIV_W-1:0])));
endmodule

// File: rtl/scl_phase_engine.sv
// Serial-clock phase engine.
// What it does: counts tick strobes through alternating low and high phases,
// each lasting divisor + D_OFF ticks. It also pulses at each clock edge.
// Assumes: D_OFF >= 1 and D_OFF <= 2**DIV_W, and the divisors stay stable
// while active.
module scl_phase_engine #(
    parameter int DIV_W = 16,
    parameter int D_OFF = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             tick,
    input  logic [DIV_W-1:0] low_div,
    input  logic [DIV_W-1:0] high_div,
    output logic             scl,
    output logic             scl_rise,
    output logic             scl_fall
);
    import scl_gen_pkg::*;

    localparam int          CNT_W = DIV_W + 1;
    localparam logic [CNT_W-1:0] OFF_M1 = CNT_W'(D_OFF - 1);

    scl_phase_e       phase;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] low_load;
    logic [CNT_W-1:0] high_load;

    // Phase reload values, taken when a phase starts
    always_comb begin
        low_load  = {1'b0, low_div}  + OFF_M1;
        high_load = {1'b0, high_div} + OFF_M1;
    end

    // Phase sequencing, tick counting and edge pulses
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            scl      <= 1'b1;
            scl_rise <= 1'b0;
            scl_fall <= 1'b0;
        end else begin
            scl_rise <= 1'b0;
            scl_fall <= 1'b0;
            if (tick) begin
                case (phase)
                    PH_IDLE: begin
                        phase    <= PH_LOW;
                        scl      <= 1'b0;
                        scl_fall <= 1'b1;
                        cnt      <= low_load;
                    end
                    PH_LOW: begin
                        if (cnt == '0) begin
                            phase    <= PH_HIGH;
                            scl      <= 1'b1;
                            scl_rise <= 1'b1;
                            cnt      <= high_load;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    PH_HIGH: begin
                        if (cnt == '0) begin
                            phase    <= PH_LOW;
                            scl      <= 1'b0;
                            scl_fall <= 1'b1;
                            cnt      <= low_load;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    // R6: inactive means released high with no pulses
    a_r6_release_high: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (scl && !scl_rise && !scl_fall));

    // R1: scl moves only on a tick
    a_r1_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick) |=> $stable(scl));

    // R9: at most one edge pulse at a time
    a_r9_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise, scl_fall}));

    // R9: falling pulse marks the first low cycle
    a_r9_fall_edge: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |-> (!scl && $past(scl)));

    // R9: rising pulse marks the first high cycle
    a_r9_rise_edge: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |-> (scl && !$past(scl)));

    // R7: the counter stays within the low phase reload
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOW) |-> (cnt <= low_load));
endmodule

// File: rtl/scl_waveform_gen.sv
// Top of the serial-clock waveform generator.
// What it does: joins the divisor registers to the phase engine, and runs the
// engine only while the controller is out of reset and is bus master.
// Assumes: tick is already prescaled and one clock wide.
module scl_waveform_gen #(
    parameter int DIV_W = 16,
    parameter int D_OFF = 5,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run_en,
    input  logic             master_en,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             scl,
    output logic             scl_rise,
    output logic             scl_fall
);
    logic [DIV_W-1:0] low_div;
    logic [DIV_W-1:0] high_div;
    logic             active;

    assign active = run_en && master_en;

    scl_div_regs #(.DIV_W(DIV_W), .REG_W(REG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock     (run_en),
        .wr_en    (reg_wr),
        .sel      (reg_addr),
        .wr_data  (reg_wdata),
        .rd_data  (reg_rdata),
        .low_div  (low_div),
        .high_div (high_div)
    );

    scl_phase_engine #(.DIV_W(DIV_W), .D_OFF(D_OFF)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .tick     (tick),
        .low_div  (low_div),
        .high_div (high_div),
        .scl      (scl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    // R4: upper read bits are zero at the ports
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata[REG_W-1:DIV_W] == '0));
endmodule

// File: tb/tb_scl_waveform_gen.sv
module tb_scl_waveform_gen;
    localparam int CLK_PERIOD = 10;
    localparam int D_OFF      = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        run_en = 1'b0;
    logic        master_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        scl, scl_rise, scl_fall;

    int n_checks = 0;
    int n_fail   = 0;
    int tick_per = 1;
    int tick_cnt = 0;
    bit done     = 1'b0;

    scl_waveform_gen dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run_en(run_en),
        .master_en(master_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl(scl),
        .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Tick strobe: every clock, or once every tick_per clocks
    always @(negedge clk) begin
        if (tick_per <= 1) begin
            tick = 1'b1;
        end else begin
            tick = (tick_cnt == 0);
            tick_cnt = (tick_cnt + 1) % tick_per;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_reg(input logic a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Sync to a fall pulse, then measure one low and one high phase in clocks
    task automatic measure(input int exp_lo, input int exp_hi, input string tag);
        int lo = 0;
        int hi = 0;
        int g = 0;
        bit rise_ok;
        @(negedge clk);
        while (!scl_fall && g < 150000) begin @(negedge clk); g++; end
        while (scl == 1'b0 && lo < 150000) begin lo++; @(negedge clk); end
        rise_ok = scl_rise;
        while (scl == 1'b1 && hi < 150000) begin
            if (hi > 0 && scl_rise) rise_ok = 1'b0;
            hi++; @(negedge clk);
        end
        check(lo == exp_lo, {tag, " low phase R1"}, lo, exp_lo);
        check(hi == exp_hi, {tag, " high phase R2"}, hi, exp_hi);
        check(rise_ok && scl_fall, {tag, " edge pulses R9"}, {rise_ok, scl_fall}, 2'b11);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check(scl == 1'b1 && !scl_rise && !scl_fall, "reset outputs R6",
              {scl, scl_rise, scl_fall}, 3'b100);
        rd_reg(1'b0, d); check(d == 0, "reset low divisor R3", d, 0);
        rd_reg(1'b1, d); check(d == 0, "reset high divisor R3", d, 0);
    endtask

    task automatic t_program;
        logic [31:0] d;
        wr_reg(1'b0, 32'hFFFF_0003);
        wr_reg(1'b1, 32'hA5A5_0007);
        rd_reg(1'b0, d); check(d == 32'h3, "low readback R3 R4", d, 3);
        rd_reg(1'b1, d); check(d == 32'h7, "high readback R3 R4", d, 7);
    endtask

    task automatic t_first_low;
        @(negedge clk);
        run_en = 1'b1; master_en = 1'b1;
        @(negedge clk);
        check(scl == 1'b0 && scl_fall, "first phase low on first tick R8",
              {scl, scl_fall}, 2'b01);
    endtask

    task automatic t_lock;
        logic [31:0] d;
        wr_reg(1'b0, 32'h0000_0100);
        wr_reg(1'b1, 32'h0000_0200);
        rd_reg(1'b0, d); check(d == 32'h3, "low locked while running R5", d, 3);
        rd_reg(1'b1, d); check(d == 32'h7, "high locked while running R5", d, 7);
        measure(3 + D_OFF, 7 + D_OFF, "after locked write R5");
    endtask

    task automatic t_not_master;
        bit bad = 1'b0;
        @(negedge clk);
        while (scl == 1'b1) @(negedge clk);
        repeat (2) @(negedge clk);
        master_en = 1'b0;
        @(negedge clk);
        check(scl == 1'b1, "mid-phase release R6", scl, 1);
        repeat (40) begin
            if (!scl || scl_rise || scl_fall) bad = 1'b1;
            @(negedge clk);
        end
        check(!bad, "idle while not master R6", bad, 0);
        master_en = 1'b1;
        @(negedge clk);
        check(scl == 1'b0 && scl_fall, "restart low R8", {scl, scl_fall}, 2'b01);
    endtask

    task automatic t_reprogram(input logic [15:0] lo, input logic [15:0] hi, input int per,
                               input string tag);
        bit bad = 1'b0;
        @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        check(scl == 1'b1, {tag, " held reset releases R6"}, scl, 1);
        wr_reg(1'b0, {16'h0, lo});
        wr_reg(1'b1, {16'h0, hi});
        repeat (5) begin
            if (!scl || scl_rise || scl_fall) bad = 1'b1;
            @(negedge clk);
        end
        check(!bad, {tag, " idle in reset R6"}, bad, 0);
        tick_per = per; tick_cnt = 0;
        run_en = 1'b1;
        measure((int'(lo) + D_OFF) * per, (int'(hi) + D_OFF) * per, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_first_low();
        measure(3 + D_OFF, 7 + D_OFF, "basic");
        t_lock();
        t_not_master();
        t_reprogram(16'd0, 16'd0, 1, "zero divisors R7");
        t_reprogram(16'd2, 16'd1, 3, "tick every third clock");
        t_reprogram(16'hFFFF, 16'd0, 1, "max low divisor R7");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule